// File: doc/BRIEF.md
# Multi-Mode Character Boundary Framer

The framer turns a stream of 10-bit raw words, cut from a serial line at an unknown phase, into properly aligned 10-bit characters. Each clock it joins the previous raw word and the current one into a 20-bit window. It looks for a framing pattern at every one of the ten bit offsets in that window. It then emits the character that starts at the selected offset. One aligned character comes out for every accepted raw word, so the output cadence never changes. Only the offset used to slice the window moves.

A static two-bit mode input picks one of three rules for when a new offset is taken. The low-latency rule moves on every framing hit. The pair rule needs a second hit at the same offset no more than five characters (50 bits) after the first. The quad rule needs four back-to-back characters that each match a full framing character in either disparity form. A one-clock realign pulse marks every change of offset. Decoding, clock recovery and serialization sit outside this block.

Top module: `char_boundary_framer`

## Requirements
- R1: While rst_ni is low, char_valid_o and realign_o are 0, offset_o is 0, char_o is 0 and no pending candidate or run is kept.
- R2: raw_i[9] is the earliest bit on the line. The character at offset k (0..9) is the 10 bits that start k bits into the previous accepted word, with its earliest bit in char_o[9]. One clock after each accepted word except the first after reset, char_valid_o is 1 and char_o holds the character at the offset selected in that step.
- R3: A framing hit at offset k is the 7 bits starting at k equal to 0011111 or 1100000. When several offsets hit in one window, the lowest offset is used, and offset_o always stays below 10.
- R4: With mode_i = 00 or 11 (low latency), any framing hit selects its offset, and the character output in that same step is already sliced at the new offset.
- R5: With mode_i = 01 (pair), a hit at an offset other than the current one becomes a candidate. A later hit at the candidate offset, one to five accepted words after it, moves the offset there, and that step's character uses the new offset.
- R6: In pair mode the candidate is dropped when five accepted words pass without a confirming hit, or when the current offset hits. A hit at another offset replaces the candidate, restarting its five-word span. None of these moves the offset.
- R7: With mode_i = 10 (quad), the offset moves to k only after four consecutive accepted words each have a full 10-bit match at offset k with 0011111010 or 1100000101. A step without a full match restarts the count, and a 7-bit pattern with a different tail never counts.
- R8: realign_o is 1 for exactly the one clock in which offset_o takes a new value, and at no other time.
- R9: A clock with raw_valid_i low changes no offset, candidate or run state, and char_valid_o is 0 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Acceptance rule: 00/11 low latency, 01 pair, 10 quad |
| raw_valid_i | input | 1 | raw_i carries a new word this clock |
| raw_i | input | 10 | Raw deserialized bits, bit 9 earliest |
| char_o | output | 10 | Aligned character, bit 9 earliest |
| char_valid_o | output | 1 | char_o holds a new character |
| offset_o | output | 4 | Bit offset currently used for slicing |
| realign_o | output | 1 | One-clock pulse when offset_o changes |

## Verification
The bench builds the framer with its default parameters: 10-bit characters, a 7-bit framing pattern, a pair span of five characters and a quad run of four. These small values let directed streams land patterns at chosen offsets. A confirming hit can be placed just inside or just outside the five-word span, and a run of three can be set against a run of four. Two hits can also share one window to test priority. Long random streams in every mode are then compared clock by clock against a behavioural model. The model keeps hit distances and a history queue instead of counters.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [1:0] {
    MODE_LOWLAT = 2'b00,
    MODE_PAIR   = 2'b01,
    MODE_QUAD   = 2'b10,
    MODE_ALT    = 2'b11
  } frm_mode_e;
endpackage

// File: rtl/frm_scan.sv
module frm_scan #(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111,
  parameter logic [CHAR_W-1:0]  CHAR_PAT  = 10'b0011111010
) (
  input  logic [2*CHAR_W-1:0] window_i,
  output logic [CHAR_W-1:0]   comma_hit_o,
  output logic [CHAR_W-1:0]   full_hit_o
);
  for (genvar k = 0; k < CHAR_W; k++) begin : g_off
    logic [COMMA_W-1:0] seg_c;
    logic [CHAR_W-1:0]  seg_f;
    assign seg_c = window_i[2*CHAR_W-1-k -: COMMA_W];
    assign seg_f = window_i[2*CHAR_W-1-k -: CHAR_W];
    assign comma_hit_o[k] = (seg_c == COMMA_PAT) || (seg_c == ~COMMA_PAT);
    assign full_hit_o[k]  = (seg_f == CHAR_PAT) || (seg_f == ~CHAR_PAT);
  end
endmodule

// File: rtl/frm_prio.sv
module frm_prio #(
  parameter int N = 10,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/frm_accept.sv
module frm_accept
  import frm_pkg::*;
#(
  parameter int PAIR_SPAN = 5,
  parameter int QUAD_RUN = 4,
  parameter int OFF_W = 4,
  localparam int AGE_W = $clog2(PAIR_SPAN + 1),
  localparam int CNT_W = $clog2(QUAD_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frm_mode_e        mode_i,
  input  logic             step_i,
  input  logic             comma_any_i,
  input  logic [OFF_W-1:0] comma_idx_i,
  input  logic             full_any_i,
  input  logic [OFF_W-1:0] full_idx_i,
  input  logic [OFF_W-1:0] cur_off_i,
  output logic             take_o,
  output logic [OFF_W-1:0] take_off_o
);
  logic             cand_vld_q, cand_vld_d;
  logic [OFF_W-1:0] cand_off_q, cand_off_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic [OFF_W-1:0] run_off_q, run_off_d;
  logic [CNT_W-1:0] run_cnt_q, run_cnt_d, cnt_n;

  always_comb begin
    take_o     = 1'b0;
    take_off_o = comma_idx_i;
    cand_vld_d = cand_vld_q;
    cand_off_d = cand_off_q;
    age_d      = age_q;
    run_off_d  = run_off_q;
    run_cnt_d  = run_cnt_q;
    cnt_n      = '0;
    if (step_i) begin
      case (mode_i)
        MODE_PAIR: begin
          run_cnt_d = '0;
          if (comma_any_i) begin
            if (comma_idx_i == cur_off_i) begin
              cand_vld_d = 1'b0;
            end else if (cand_vld_q && cand_off_q == comma_idx_i) begin
              take_o     = 1'b1;
              cand_vld_d = 1'b0;
            end else begin
              cand_vld_d = 1'b1;
              cand_off_d = comma_idx_i;
              age_d      = '0;
            end
          end else if (cand_vld_q) begin
            // span used up: next hit would be too far
            if (age_q == AGE_W'(PAIR_SPAN - 1)) cand_vld_d = 1'b0;
            else age_d = age_q + 1'b1;
          end
        end
        MODE_QUAD: begin
          cand_vld_d = 1'b0;
          take_off_o = full_idx_i;
          if (full_any_i) begin
            if (run_cnt_q != '0 && run_off_q == full_idx_i) cnt_n = run_cnt_q + 1'b1;
            else cnt_n = CNT_W'(1);
            run_off_d = full_idx_i;
            if (cnt_n == CNT_W'(QUAD_RUN)) begin
              take_o    = 1'b1;
              run_cnt_d = '0;
            end else begin
              run_cnt_d = cnt_n;
            end
          end else begin
            run_cnt_d = '0;
          end
        end
        default: begin
          cand_vld_d = 1'b0;
          run_cnt_d  = '0;
          take_o     = comma_any_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_vld_q <= 1'b0;
      cand_off_q <= '0;
      age_q      <= '0;
      run_off_q  <= '0;
      run_cnt_q  <= '0;
    end else begin
      cand_vld_q <= cand_vld_d;
      cand_off_q <= cand_off_d;
      age_q      <= age_d;
      run_off_q  <= run_off_d;
      run_cnt_q  <= run_cnt_d;
    end
  end

  assert_cand_age_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_vld_q |-> (age_q < AGE_W'(PAIR_SPAN)));

  assert_run_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_q < CNT_W'(QUAD_RUN));

  assert_quad_needs_char_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && mode_i == MODE_QUAD) |-> (full_any_i && run_cnt_q == CNT_W'(QUAD_RUN - 1)));

  assert_take_needs_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> step_i);
endmodule

// File: rtl/char_boundary_framer.sv
module char_boundary_framer
  import frm_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int COMMA_W = 7,
  parameter int PAIR_SPAN = 5,
  parameter int QUAD_RUN = 4,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111,
  parameter logic [CHAR_W-1:0]  CHAR_PAT  = 10'b0011111010,
  localparam int OFF_W = $clog2(CHAR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              raw_valid_i,
  input  logic [CHAR_W-1:0] raw_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_valid_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              realign_o
);
  logic [CHAR_W-1:0]   prev_q, char_q;
  logic                have_prev_q, char_valid_q, realign_q;
  logic [OFF_W-1:0]    offset_q, sel;
  logic [2*CHAR_W-1:0] window;
  logic [CHAR_W-1:0]   comma_hit, full_hit;
  logic                comma_any, full_any, take, step;
  logic [OFF_W-1:0]    comma_idx, full_idx, take_off;
  logic [CHAR_W-1:0]   slice [CHAR_W];
  frm_mode_e           mode;

  assign mode   = frm_mode_e'(mode_i);
  assign window = {prev_q, raw_i};
  assign step   = raw_valid_i && have_prev_q;

  for (genvar k = 0; k < CHAR_W; k++) begin : g_slice
    assign slice[k] = window[2*CHAR_W-1-k -: CHAR_W];
  end

  frm_scan #(
    .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT), .CHAR_PAT(CHAR_PAT)
  ) u_scan (
    .window_i(window), .comma_hit_o(comma_hit), .full_hit_o(full_hit)
  );

  frm_prio #(.N(CHAR_W), .IDX_W(OFF_W)) u_comma_prio (
    .req_i(comma_hit), .any_o(comma_any), .idx_o(comma_idx)
  );

  frm_prio #(.N(CHAR_W), .IDX_W(OFF_W)) u_full_prio (
    .req_i(full_hit), .any_o(full_any), .idx_o(full_idx)
  );

  frm_accept #(.PAIR_SPAN(PAIR_SPAN), .QUAD_RUN(QUAD_RUN), .OFF_W(OFF_W)) u_acc (
    .clk_i, .rst_ni, .mode_i(mode), .step_i(step),
    .comma_any_i(comma_any), .comma_idx_i(comma_idx),
    .full_any_i(full_any), .full_idx_i(full_idx),
    .cur_off_i(offset_q), .take_o(take), .take_off_o(take_off)
  );

  assign sel = take ? take_off : offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= '0;
      have_prev_q  <= 1'b0;
      char_q       <= '0;
      char_valid_q <= 1'b0;
      realign_q    <= 1'b0;
      offset_q     <= '0;
    end else begin
      if (raw_valid_i) begin
        prev_q      <= raw_i;
        have_prev_q <= 1'b1;
      end
      char_valid_q <= step;
      realign_q    <= step && (sel != offset_q);
      if (step) begin
        offset_q <= sel;
        char_q   <= slice[sel];
      end
    end
  end

  assign char_o       = char_q;
  assign char_valid_o = char_valid_q;
  assign offset_o     = offset_q;
  assign realign_o    = realign_q;

  assert_realign_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_q |-> (offset_q != $past(offset_q)));

  assert_offset_move_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offset_q != $past(offset_q)) |-> realign_q);

  assert_offset_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_q < OFF_W'(CHAR_W));

  assert_hold_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_valid_i |=> ($stable(offset_q) && !char_valid_q));

  assert_valid_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_q |-> $past(raw_valid_i));
endmodule

// File: tb/char_boundary_framer_tb_top.sv
module char_boundary_framer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       raw_valid_i = 1'b0;
  logic [9:0] raw_i = '0;
  logic [9:0] char_o;
  logic       char_valid_o;
  logic [3:0] offset_o;
  logic       realign_o;

  char_boundary_framer dut_i (
    .clk_i, .rst_ni, .mode_i, .raw_valid_i, .raw_i,
    .char_o, .char_valid_o, .offset_o, .realign_o
  );

  always #10 clk_i = ~clk_i;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // stream source
  bit bq[$];
  int tot = 0;
  bit last_b = 1'b0;

  // reference model state
  int m_prev = 0, m_have = 0, m_off = 0, m_idx = 0;
  int m_cand = -1, m_cand_at = 0;
  int hist[$];
  int exp_char = 0, exp_valid = 0, exp_realign = 0;
  string cur_tag = "R2";

  task automatic push_bit(input bit b);
    bq.push_back(b);
    tot++;
    last_b = b;
  endtask

  task automatic push_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) push_bit(v[i]);
  endtask

  task automatic push_fill(input int n);
    for (int i = 0; i < n; i++) push_bit(~last_b);
  endtask

  // pad so the next bit lands at offset k of a word
  task automatic place(input int k, input int extra);
    push_fill(((k - (tot % 10) + 10) % 10) + extra);
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic [9:0] w);
    int wb[20];
    int ch, fh, nxt, s;
    bit all_eq;
    if (m_have != 0) begin
      for (int i = 0; i < 10; i++) begin
        wb[i] = (m_prev >> (9 - i)) & 1;
        wb[10 + i] = w[9 - i];
      end
      ch = -1;
      fh = -1;
      for (int k = 9; k >= 0; k--) begin
        s = 0;
        for (int j = 0; j < 7; j++) s = s * 2 + wb[k + j];
        if (s == 'h1F || s == 'h60) ch = k;
        s = 0;
        for (int j = 0; j < 10; j++) s = s * 2 + wb[k + j];
        if (s == 'h0FA || s == 'h305) fh = k;
      end
      m_idx++;
      nxt = m_off;
      case (mode_i)
        2'b01: begin
          hist.delete();
          if (ch >= 0) begin
            if (ch == m_off) m_cand = -1;
            else if (m_cand == ch && (m_idx - m_cand_at) <= 5) begin
              nxt = ch;
              m_cand = -1;
            end else begin
              m_cand = ch;
              m_cand_at = m_idx;
            end
          end
        end
        2'b10: begin
          m_cand = -1;
          hist.push_back(fh);
          if (hist.size() > 4) void'(hist.pop_front());
          all_eq = (hist.size() == 4) && (fh >= 0);
          foreach (hist[i]) if (hist[i] != fh) all_eq = 1'b0;
          if (all_eq) begin
            nxt = fh;
            hist.delete();
          end
        end
        default: begin
          m_cand = -1;
          hist.delete();
          if (ch >= 0) nxt = ch;
        end
      endcase
      exp_realign = (nxt != m_off);
      m_off = nxt;
      s = 0;
      for (int j = 0; j < 10; j++) s = s * 2 + wb[nxt + j];
      exp_char = s;
      exp_valid = 1;
    end else begin
      exp_valid = 0;
      exp_realign = 0;
    end
    m_prev = w;
    m_have = 1;
  endtask

  task automatic cyc(input bit v);
    logic [9:0] w;
    @(negedge clk_i);
    check("R2", "char_o", char_o, exp_char);
    check("R2", "char_valid_o", char_valid_o, exp_valid);
    check("R8", "realign_o", realign_o, exp_realign);
    check(cur_tag, "offset_o", offset_o, m_off);
    if (v) begin
      if (bq.size() < 10) push_fill(10 - bq.size());
      for (int i = 9; i >= 0; i--) w[i] = bq.pop_front();
      model_step(w);
      raw_i = w;
      raw_valid_i = 1'b1;
    end else begin
      raw_valid_i = 1'b0;
      exp_valid = 0;
      exp_realign = 0;
    end
  endtask

  task automatic settle();
    push_fill(70);
    while (bq.size() >= 10) cyc(1'b1);
    cyc(1'b0);
  endtask

  localparam logic [9:0] KP = 10'b0011111010;
  localparam logic [9:0] KN = 10'b1100000101;

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "char_valid_o", char_valid_o, 0);
    check("R1", "offset_o", offset_o, 0);
    check("R1", "realign_o", realign_o, 0);
    check("R1", "char_o", char_o, 0);
    rst_ni = 1'b1;

    // low latency
    mode_i = 2'b00; cur_tag = "R4";
    place(3, 40); push_bits(16'(KP), 10); settle();
    check("R4", "offset after hit at 3", offset_o, 3);
    place(7, 20); push_bits(16'(KN), 10); settle();
    check("R4", "offset after hit at 7", offset_o, 7);
    cur_tag = "R3";
    place(0, 20); push_bits(16'b0011111, 7); push_bits(16'b10, 2); push_bits(16'b1100000, 7);
    settle();
    check("R3", "lowest offset wins", offset_o, 0);

    // pair
    mode_i = 2'b01; cur_tag = "R6";
    place(5, 20); push_bits(16'(KP), 10); push_fill(50); push_bits(16'(KP), 10); settle();
    check("R6", "pair 60 bits apart ignored", offset_o, 0);
    cur_tag = "R5";
    place(5, 20); push_bits(16'(KP), 10); push_fill(40); push_bits(16'(KN), 10); settle();
    check("R5", "pair 50 bits apart taken", offset_o, 5);
    cur_tag = "R6";
    place(2, 20); push_bits(16'(KP), 10); place(8, 0); push_bits(16'(KP), 10);
    place(2, 0); push_bits(16'(KP), 10); settle();
    check("R6", "candidate replaced", offset_o, 5);
    place(7, 20); push_bits(16'(KP), 10); place(5, 0); push_bits(16'(KP), 10);
    place(7, 0); push_bits(16'(KP), 10); settle();
    check("R6", "current-offset hit clears", offset_o, 5);
    cur_tag = "R5";
    place(2, 20); push_bits(16'(KP), 10); push_bits(16'(KN), 10); settle();
    check("R5", "adjacent pair taken", offset_o, 2);

    // quad
    mode_i = 2'b10; cur_tag = "R7";
    place(6, 20); push_bits(16'(KP), 10); push_bits(16'(KN), 10); push_bits(16'(KP), 10);
    settle();
    check("R7", "three in a row ignored", offset_o, 2);
    place(6, 20);
    for (int i = 0; i < 4; i++) push_bits(16'((i % 2 == 0) ? KN : KP), 10);
    settle();
    check("R7", "four in a row taken", offset_o, 6);
    place(1, 20);
    for (int i = 0; i < 4; i++) push_bits(16'b0011111110, 10);
    settle();
    check("R7", "short pattern ignored", offset_o, 6);

    // alternate code behaves as low latency
    mode_i = 2'b11; cur_tag = "R4";
    place(1, 20); push_bits(16'(KP), 10); settle();
    check("R4", "mode 11 low latency", offset_o, 1);

    // idle gaps
    mode_i = 2'b00; cur_tag = "R9";
    place(4, 20); push_bits(16'(KN), 10); push_fill(30);
    while (bq.size() >= 10) begin
      cyc(1'b1);
      cyc(1'b0);
    end
    cyc(1'b0);
    check("R9", "char_valid_o after idle", char_valid_o, 0);
    check("R9", "offset after gapped hit", offset_o, 4);

    // random streams in every mode
    cur_tag = "R2";
    for (int m = 0; m < 4; m++) begin
      mode_i = 2'(m);
      for (int i = 0; i < 1500; i++) push_bit(1'($urandom_range(0, 1)));
      while (bq.size() >= 10) begin
        cyc(1'b1);
        if ($urandom_range(0, 7) == 0) cyc(1'b0);
      end
    end
    cyc(1'b0);
    cyc(1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule